// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block makes a group of agents meet at a common point. Each agent pulses its own arrive input when it reaches the barrier. It is then held, with its released output low, until the configured number of agents has arrived. When the last one arrives, every participant is let go in the same cycle.

Each agent has a private sense bit, and the block keeps one shared release flag and one arrival counter. The agent that completes an episode does not set the flag to a fixed value. It turns the flag over to the sense that the arriving agents carried into this episode. Because of this, an agent that comes straight back after a release cannot mistake the old flag for a new release. It may arrive again in the very next cycle.

The number of participants is read from a configuration input while reset is held. Participants are the agents with the lowest indices.

Top module: `sense_barrier`

## Requirements
- R1: While reset is held and in the first cycle after it, every `released_o` bit is 1, the release flag is 0 and the arrival count is 0.
- R2: The participant total is loaded from `cfg_total_i` only while `rst_i` is high. A value of 0, or a value above `N_AGENTS`, loads `N_AGENTS`. Changes to `cfg_total_i` outside reset have no effect.
- R3: Only agents whose index is below the total take part. Arrive pulses from other agents are ignored, and their `released_o` stays 1.
- R4: An accepted arrival inverts that agent's sense bit, which starts at 1. If the arrival does not complete the episode, the agent's `released_o` reads 0 from the next cycle.
- R5: Held agents stay at `released_o` = 0 until the number of accepted arrivals in the episode equals the total.
- R6: On the clock edge where the count reaches the total, the count returns to 0 and the flag inverts. From the next cycle, every participant's `released_o` is 1.
- R7: Arrivals from several agents in the same cycle are all counted in that cycle.
- R8: An arrive pulse from an agent that is already held in the current episode is ignored and does not add to the count.
- R9: An agent may arrive again in the cycle right after a release. It is then held until the new episode completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; the total is loaded while it is high |
| cfg_total_i | input | CNT_W | Requested number of participants |
| arrive_i | input | N_AGENTS | One-cycle arrival pulse per agent |
| released_o | output | N_AGENTS | High while the agent is not held at the barrier |

## Verification
The hardest situation to bring about is a held agent pulsing arrive again while the episode is still open. The extra pulse must leave the count alone, and the mistake only shows later, as a release that comes one arrival too early. The stimulus repeats an agent's pulse and then supplies exactly one arrival short of the total, so the bench can see that the group is still held. A second hard case is re-entry in the cycle right after a release. The bench drives a new arrival on the first falling edge after the completing edge and expects that agent to be held.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

   // Maps a requested participant total onto the legal range 1..n.
   function automatic int fit_total(input int raw, input int n);
      if (raw == 0 || raw > n) return n;
      return raw;
   endfunction

endpackage

// File: rtl/barrier_sense_slot.sv
module barrier_sense_slot (
   input  logic clk_i,
   input  logic rst_i,
   input  logic arrive_i,
   input  logic part_en_i,
   input  logic flag_i,
   output logic accept_o,
   output logic released_o
);
   logic sense_q;
   logic held;

   // An agent is held once the flag equals its freshly inverted sense.
   assign held       = part_en_i && (flag_i == sense_q);
   assign accept_o   = arrive_i && part_en_i && !held;
   assign released_o = !held;

   always_ff @(posedge clk_i) begin
      if (rst_i)         sense_q <= 1'b1;
      else if (accept_o) sense_q <= !sense_q;
   end

   assert_sense_flip_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      accept_o |=> (sense_q != $past(sense_q)));

   assert_dup_ignored_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (arrive_i && held) |=> $stable(sense_q));

   assert_idle_agent_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      !part_en_i |-> released_o);
endmodule

// File: rtl/barrier_arrival_counter.sv
module barrier_arrival_counter #(
   parameter int N_AGENTS = 4,
   localparam int CNT_W = $clog2(N_AGENTS + 1)
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [CNT_W-1:0]    cfg_total_i,
   input  logic [N_AGENTS-1:0] accept_i,
   output logic                flag_o,
   output logic [N_AGENTS-1:0] part_mask_o
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] total_q;
   logic             flag_q;
   logic [CNT_W:0]   psum [N_AGENTS+1];
   logic [CNT_W:0]   sum;
   logic             done;

   // Chain of partial sums so that simultaneous arrivals are all counted.
   assign psum[0] = '0;
   for (genvar i = 0; i < N_AGENTS; i++) begin : g_pop
      assign psum[i+1] = psum[i] + {{CNT_W{1'b0}}, accept_i[i]};
      assign part_mask_o[i] = (CNT_W'(i) < total_q);
   end

   assign sum  = {1'b0, count_q} + psum[N_AGENTS];
   assign done = (sum >= {1'b0, total_q});

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q <= '0;
         flag_q  <= 1'b0;
         total_q <= CNT_W'(barrier_pkg::fit_total(int'(cfg_total_i), N_AGENTS));
      end else if (done) begin
         count_q <= '0;
         flag_q  <= !flag_q;
      end else begin
         count_q <= sum[CNT_W-1:0];
      end
   end

   assign flag_o = flag_q;

   assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      count_q < total_q);

   assert_flip_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(flag_q) |-> (count_q == '0));
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
   parameter int N_AGENTS = 4,
   localparam int CNT_W = $clog2(N_AGENTS + 1)
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [CNT_W-1:0]    cfg_total_i,
   input  logic [N_AGENTS-1:0] arrive_i,
   output logic [N_AGENTS-1:0] released_o
);
   if (N_AGENTS < 2) begin : g_bad_agents
      $error("sense_barrier needs at least two agents");
   end

   logic                flag;
   logic [N_AGENTS-1:0] part_mask;
   logic [N_AGENTS-1:0] accept;

   barrier_arrival_counter #(.N_AGENTS(N_AGENTS)) counter_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .cfg_total_i (cfg_total_i),
      .accept_i    (accept),
      .flag_o      (flag),
      .part_mask_o (part_mask)
   );

   for (genvar i = 0; i < N_AGENTS; i++) begin : g_slot
      barrier_sense_slot slot_i (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .arrive_i   (arrive_i[i]),
         .part_en_i  (part_mask[i]),
         .flag_i     (flag),
         .accept_o   (accept[i]),
         .released_o (released_o[i])
      );
   end

   assert_release_all_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(flag) |-> &(released_o | ~part_mask));

   assert_total_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      $stable(part_mask));
endmodule

// File: tb/sense_barrier_tb.sv
module sense_barrier_tb_top;
   localparam int N = 4;
   localparam int CW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CW-1:0] cfg = '0;
   logic [N-1:0]  arr = '0;
   logic [N-1:0]  rel;
   int            checks = 0;
   int            failures = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   sense_barrier #(.N_AGENTS(N)) dut_i (
      .clk_i(clk), .rst_i(rst), .cfg_total_i(cfg), .arrive_i(arr), .released_o(rel)
   );

   task automatic check(input logic [N-1:0] exp, input string tag);
      checks++;
      if (rel !== exp) begin
         failures++;
         $display("FAIL %s released=%b expected=%b", tag, rel, exp);
      end
   endtask

   task automatic do_reset(input logic [CW-1:0] total);
      @(negedge clk);
      rst = 1'b1; cfg = total; arr = '0;
      @(negedge clk);
      check('1, "R1 during reset");
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check('1, "R1 after reset");
   endtask

   // Drive a one-cycle arrival pattern, then compare released_o one cycle later.
   task automatic pulse(input logic [N-1:0] who, input logic [N-1:0] exp, input string tag);
      arr = who;
      @(negedge clk);
      arr = '0;
      check(exp, tag);
   endtask

   task automatic t_basic;
      do_reset(CW'(4));
      pulse(4'b0001, 4'b1110, "R4 first arrival held");
      pulse(4'b0010, 4'b1100, "R5 second held");
      pulse(4'b0100, 4'b1000, "R5 third held");
      @(negedge clk);
      check(4'b1000, "R5 still held without arrival");
      pulse(4'b1000, 4'b1111, "R6 last arrival releases all");
   endtask

   task automatic t_same_cycle;
      pulse(4'b0011, 4'b1100, "R7 two together held");
      pulse(4'b1100, 4'b1111, "R7 two together complete");
      pulse(4'b1111, 4'b1111, "R7 all four in one cycle");
   endtask

   task automatic t_duplicate;
      pulse(4'b0001, 4'b1110, "R8 first arrival");
      pulse(4'b0001, 4'b1110, "R8 repeat pulse ignored");
      pulse(4'b0010, 4'b1100, "R8 second agent");
      pulse(4'b0100, 4'b1000, "R8 repeat not counted");
      pulse(4'b1000, 4'b1111, "R8 release at true total");
   endtask

   task automatic t_reentry;
      pulse(4'b0111, 4'b1000, "R9 three held");
      pulse(4'b1000, 4'b1111, "R9 released");
      pulse(4'b0001, 4'b1110, "R9 immediate re-entry held");
      pulse(4'b0110, 4'b1000, "R9 new episode holds");
      pulse(4'b1000, 4'b1111, "R9 new episode releases");
   endtask

   task automatic t_partial;
      do_reset(CW'(2));
      pulse(4'b0100, 4'b1111, "R3 non-participant ignored");
      pulse(4'b1001, 4'b1110, "R3 agent0 held, agent3 ignored");
      cfg = CW'(3);
      pulse(4'b0010, 4'b1111, "R2 total of two stays after cfg change");
      pulse(4'b0001, 4'b1110, "R2 next episode");
      pulse(4'b0010, 4'b1111, "R2 two-agent release");
   endtask

   task automatic t_clamp;
      do_reset(CW'(6));
      pulse(4'b0111, 4'b1000, "R2 clamped total holds three");
      pulse(4'b1000, 4'b1111, "R2 clamped total releases at four");
      do_reset(CW'(0));
      pulse(4'b1011, 4'b0100, "R2 zero means all agents");
      pulse(4'b0100, 4'b1111, "R2 zero total release");
   endtask

   initial begin
      t_basic();
      t_same_cycle();
      t_duplicate();
      t_reentry();
      t_partial();
      t_clamp();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule